// File: doc/BRIEF.md
# Dot Clock Source Select and Divider

This block produces the pixel clock enable and the character clock enable for a legacy graphics controller. Four candidate oscillators reach the block as single-cycle tick strobes, all in the domain of one fast reference clock. These are the bus oscillator, the high-resolution oscillator, the external clock from the feature connector and a spare input. A two-bit field in the miscellaneous output register picks one of them.

The chosen ticks pass through two halving stages and then a character counter. The first stage is a pre-divider set by an extended CRTC register. The second is the standard sequencer halving bit. The pre-divider lets a board fitted with double-frequency oscillators still produce the standard dot rates. Software programs all of these settings through the usual index/data register ports on an 8-bit I/O bus. New settings are held back and take effect together at the next character boundary.

Top module: `dclk_gen`

## Requirements
- R1: While reset is low, `dot_ce` and `char_ce` are 0. After reset every register reads 0, so the source is select 00, both dividers are off and characters are 9 dots wide.
- R2: Bits 3:2 of the miscellaneous output register at port 0x3C2 pick the source: 00 picks `src_tick[0]` (bus oscillator), 01 picks `src_tick[1]`, 10 picks `src_tick[2]` (external) and 11 picks `src_tick[3]` (spare). With no divider on, `dot_ce` follows the chosen source one cycle later, at the same rate.
- R3: The sequencer index port is 0x3C4 and its data port is 0x3C5. Setting bit 3 of sequencer register 1 (clocking mode) halves the dot rate.
- R4: The CRTC index/data ports are 0x3B4/0x3B5 and 0x3D4/0x3D5, and both pairs reach the same registers. Bit 0 of CRTC register 0xF9 enables a divide-by-two placed ahead of the sequencer halving. Value 3 turns it on and value 0 turns it off.
- R5: With both dividers on, the dot period is four source periods.
- R6: Bit 0 of sequencer register 1 sets the character width: 1 gives 8 dots, 0 gives 9 dots. `char_ce` pulses on every 8th or 9th `dot_ce` and only in the same cycle as a `dot_ce`.
- R7: Each `dot_ce` comes one cycle after a tick of the active source. No stage produces an extra or partial pulse.
- R8: Changes to the select, divider or width bits take effect only at the next `char_ce`. Dots inside the current character keep the old rate.
- R9: `bus_rdata` returns the register at `bus_addr`: miscellaneous output, both index registers, sequencer register 1 and CRTC register 0xF9. Writes to other indices or to unmapped ports change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | Tick strobes of the four oscillators |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 10 | I/O port address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the port at `bus_addr` |
| dot_ce | output | 1 | Dot clock enable |
| char_ce | output | 1 | Character clock enable |

## Verification
A wrong active select or a stuck divider phase shows up as a dot period at `dot_ce` that is off by a whole factor. This is visible within two dot pulses after the configuration takes effect. A wrong character count shows as a `char_ce` spacing of the wrong number of dot periods, visible after one character. An early apply of new settings shows as a change of dot period before the character ends. A decode error shows at once on `bus_rdata`.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

  localparam int SRC_COUNT = 4;
  localparam int SEL_W     = $clog2(SRC_COUNT);

  // port offsets inside each 16-port range
  localparam logic [3:0] OFS_MISC  = 4'h2;
  localparam logic [3:0] OFS_SEQ_I = 4'h4;
  localparam logic [3:0] OFS_SEQ_D = 4'h5;
  localparam logic [3:0] OFS_CRT_I = 4'h4;
  localparam logic [3:0] OFS_CRT_D = 4'h5;

  localparam logic [7:0] SEQ_CLKMODE_IDX = 8'h01;
  localparam logic [7:0] CRT_PREDIV_IDX  = 8'hF9;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             pre;
    logic             half;
    logic             nine;
  } clk_cfg_t;

  function automatic logic [SEL_W-1:0] misc_to_sel(input logic [7:0] misc);
    return misc[3:2];
  endfunction

  function automatic logic clkmode_half(input logic [7:0] cm);
    return cm[3];
  endfunction

  function automatic logic clkmode_nine(input logic [7:0] cm);
    return ~cm[0];
  endfunction

  function automatic logic prediv_on(input logic [7:0] v);
    return v[0];
  endfunction

  // last counter value within a character
  function automatic logic [3:0] last_dot(input logic nine);
    return nine ? 4'd8 : 4'd7;
  endfunction

endpackage

// File: rtl/dclk_regs.sv
module dclk_regs
  import dclk_pkg::*;
#(
  parameter logic [9:0] ADAPTER_BASE = 10'h3C0,
  parameter logic [9:0] MONO_BASE    = 10'h3B0,
  parameter logic [9:0] COLOR_BASE   = 10'h3D0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [9:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [7:0] misc_q,
  output clk_cfg_t   cfg
);

  logic [7:0] seq_idx_q, seq_cm_q, crt_idx_q, crt_pre_q;

  logic hit_misc, hit_seq_i, hit_seq_d, hit_crt_i, hit_crt_d;
  logic in_mono, in_color;

  assign in_mono  = (bus_addr[9:4] == MONO_BASE[9:4]);
  assign in_color = (bus_addr[9:4] == COLOR_BASE[9:4]);

  assign hit_misc  = (bus_addr == (ADAPTER_BASE | {6'd0, OFS_MISC}));
  assign hit_seq_i = (bus_addr == (ADAPTER_BASE | {6'd0, OFS_SEQ_I}));
  assign hit_seq_d = (bus_addr == (ADAPTER_BASE | {6'd0, OFS_SEQ_D}));
  assign hit_crt_i = (in_mono || in_color) && (bus_addr[3:0] == OFS_CRT_I);
  assign hit_crt_d = (in_mono || in_color) && (bus_addr[3:0] == OFS_CRT_D);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      misc_q    <= '0;
      seq_idx_q <= '0;
      seq_cm_q  <= '0;
      crt_idx_q <= '0;
      crt_pre_q <= '0;
    end else if (bus_wr) begin
      if (hit_misc)  misc_q    <= bus_wdata;
      if (hit_seq_i) seq_idx_q <= bus_wdata;
      if (hit_crt_i) crt_idx_q <= bus_wdata;
      if (hit_seq_d && seq_idx_q == SEQ_CLKMODE_IDX) seq_cm_q  <= bus_wdata;
      if (hit_crt_d && crt_idx_q == CRT_PREDIV_IDX)  crt_pre_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_misc)  bus_rdata = misc_q;
    if (hit_seq_i) bus_rdata = seq_idx_q;
    if (hit_crt_i) bus_rdata = crt_idx_q;
    if (hit_seq_d && seq_idx_q == SEQ_CLKMODE_IDX) bus_rdata = seq_cm_q;
    if (hit_crt_d && crt_idx_q == CRT_PREDIV_IDX)  bus_rdata = crt_pre_q;
  end

  assign cfg.sel  = misc_to_sel(misc_q);
  assign cfg.pre  = prediv_on(crt_pre_q);
  assign cfg.half = clkmode_half(seq_cm_q);
  assign cfg.nine = clkmode_nine(seq_cm_q);

endmodule

// File: rtl/dclk_half.sv
module dclk_half (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic enable,
  input  logic restart,
  output logic tick_out
);

  logic ph_q;

  // passes the second of every pair of input ticks when enabled
  assign tick_out = tick_in && (!enable || ph_q);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) ph_q <= 1'b0;
    else if (tick_in && enable) ph_q <= ~ph_q;
  end

endmodule

// File: rtl/dclk_charcnt.sv
module dclk_charcnt
  import dclk_pkg::*;
#(
  parameter int MAX_DOTS = 9,
  localparam int CNT_W = $clog2(MAX_DOTS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dot_in,
  input  logic nine,
  output logic char_end
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last     = CNT_W'(last_dot(nine));
  assign char_end = dot_in && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (char_end) cnt_q <= '0;
    else if (dot_in) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/dclk_gen.sv
module dclk_gen
  import dclk_pkg::*;
#(
  parameter logic [9:0] ADAPTER_BASE = 10'h3C0,
  parameter logic [9:0] MONO_BASE    = 10'h3B0,
  parameter logic [9:0] COLOR_BASE   = 10'h3D0,
  parameter int         MAX_DOTS     = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_COUNT-1:0] src_tick,
  input  logic                 bus_wr,
  input  logic [9:0]           bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic                 dot_ce,
  output logic                 char_ce
);

  clk_cfg_t   pend_cfg, act_cfg;
  logic [7:0] misc_q;
  logic       sel_tick, pre_tick, dot_en, char_en;

  dclk_regs #(
    .ADAPTER_BASE(ADAPTER_BASE),
    .MONO_BASE   (MONO_BASE),
    .COLOR_BASE  (COLOR_BASE)
  ) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .misc_q   (misc_q),
    .cfg      (pend_cfg)
  );

  assign sel_tick = src_tick[act_cfg.sel];

  dclk_half i_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_in (sel_tick),
    .enable  (act_cfg.pre),
    .restart (char_en),
    .tick_out(pre_tick)
  );

  dclk_half i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_in (pre_tick),
    .enable  (act_cfg.half),
    .restart (char_en),
    .tick_out(dot_en)
  );

  dclk_charcnt #(.MAX_DOTS(MAX_DOTS)) i_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .dot_in  (dot_en),
    .nine    (act_cfg.nine),
    .char_end(char_en)
  );

  // settings move into the active set only on a character boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_cfg <= '{sel: '0, pre: 1'b0, half: 1'b0, nine: 1'b1};
      dot_ce  <= 1'b0;
      char_ce <= 1'b0;
    end else begin
      if (char_en) act_cfg <= pend_cfg;
      dot_ce  <= dot_en;
      char_ce <= char_en;
    end
  end

endmodule

// File: rtl/dclk_gen_chk.sv
module dclk_gen_chk
  import dclk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [9:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] misc_q,
  input logic       sel_tick,
  input logic [4:0] act_bits,
  input logic       dot_ce,
  input logic       char_ce
);

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    !rst_n |=> (!dot_ce && !char_ce)); // R1

  AST_MISC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 10'h3C2) |=> (misc_q == $past(bus_wdata))); // R2

  AST_CHAR_ON_DOT: assert property (@(posedge clk) disable iff (!rst_n)
    char_ce |-> dot_ce); // R6

  AST_DOT_FROM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    dot_ce |-> $past(sel_tick)); // R7

  AST_APPLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_bits) |-> char_ce); // R8

endmodule

bind dclk_gen dclk_gen_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .misc_q   (misc_q),
  .sel_tick (sel_tick),
  .act_bits (act_cfg),
  .dot_ce   (dot_ce),
  .char_ce  (char_ce)
);

// File: tb/test_dclk_gen.sv
module test_dclk_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] src_tick = '0;
  logic       bus_wr = 0;
  logic [9:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       dot_ce, char_ce;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dclk_gen i_dclk_gen (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dot_ce(dot_ce), .char_ce(char_ce)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // source k ticks once every k+2 reference cycles
  initial begin
    int cnt [4];
    for (int k = 0; k < 4; k++) cnt[k] = 0;
    forever begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        src_tick[k] = (cnt[k] == k + 1);
        cnt[k] = (cnt[k] == k + 1) ? 0 : cnt[k] + 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [9:0] a, output int d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // cycles between the next two pulses of dot_ce (which=0) or char_ce
  task automatic period(input bit which, output int p);
    @(negedge clk);
    while (!(which ? char_ce : dot_ce)) @(negedge clk);
    p = 0;
    do begin @(negedge clk); p++; end while (!(which ? char_ce : dot_ce));
  endtask

  task automatic settle();
    int p;
    period(1, p);
  endtask

  task automatic set_seq(input logic [7:0] v);
    wr(10'h3C4, 8'h01); wr(10'h3C5, v);
  endtask

  task automatic set_pre(input logic [9:0] base, input logic [7:0] v);
    wr(base | 10'h4, 8'hF9); wr(base | 10'h5, v);
  endtask

  task automatic t_reset();
    int v, p;
    repeat (3) @(negedge clk);
    check("R1 dot_ce in reset", dot_ce, 0);
    check("R1 char_ce in reset", char_ce, 0);
    rst_n = 1;
    rd(10'h3C2, v); check("R1 misc reset", v, 0);
    rd(10'h3C4, v); check("R1 seq index reset", v, 0);
    rd(10'h3D4, v); check("R1 crtc index reset", v, 0);
    period(0, p); check("R1 dot period default", p, 2);
    period(1, p); check("R1 char period 9 dots", p, 18);
  endtask

  task automatic t_select();
    int p;
    for (int s = 0; s < 4; s++) begin
      wr(10'h3C2, 8'(s << 2));
      settle();
      period(0, p); check("R2 source select period", p, s + 2);
    end
    wr(10'h3C2, 8'h04);
    settle();
  endtask

  task automatic t_half();
    int p, v;
    set_seq(8'h08);
    settle();
    period(0, p); check("R3 sequencer halving", p, 6);
    rd(10'h3C5, v); check("R3 clocking mode readback", v, 8'h08);
    set_seq(8'h00);
    settle();
  endtask

  task automatic t_pre();
    int p, v;
    set_pre(10'h3D0, 8'h03);
    settle();
    period(0, p); check("R4 pre-divider via colour CRTC", p, 6);
    wr(10'h3B4, 8'hF9);
    rd(10'h3B5, v); check("R4 shared register via mono CRTC", v, 3);
    set_seq(8'h08);
    settle();
    period(0, p); check("R5 both dividers", p, 12);
    period(1, p); check("R5 char period with both", p, 108);
    set_pre(10'h3B0, 8'h00);
    set_seq(8'h00);
    settle();
    period(0, p); check("R4 pre-divider off", p, 3);
  endtask

  task automatic t_width();
    int p;
    wr(10'h3C2, 8'h08);
    set_seq(8'h01);
    settle();
    period(1, p); check("R6 8-dot char period", p, 32);
    set_seq(8'h00);
    settle();
    period(1, p); check("R6 9-dot char period", p, 36);
  endtask

  task automatic t_boundary();
    int p;
    wr(10'h3C2, 8'h00);
    set_seq(8'h01);
    settle();
    @(negedge clk);
    while (!char_ce) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      while (!dot_ce) @(negedge clk);
    end
    wr(10'h3C2, 8'h0C);
    period(0, p); check("R8 old rate kept mid-character", p, 2);
    @(negedge clk);
    while (!char_ce) @(negedge clk);
    period(0, p); check("R8 new rate after boundary", p, 5);
  endtask

  task automatic t_ignore();
    int p, v;
    wr(10'h3C4, 8'h02); wr(10'h3C5, 8'hFF);
    wr(10'h3D4, 8'h0A); wr(10'h3D5, 8'hFF);
    wr(10'h3C6, 8'hFF); wr(10'h3E4, 8'hF9); wr(10'h3E5, 8'hFF);
    rd(10'h3C5, v); check("R9 other seq index reads 0", v, 0);
    wr(10'h3C4, 8'h01);
    rd(10'h3C5, v); check("R9 clocking mode untouched", v, 8'h01);
    wr(10'h3D4, 8'hF9);
    rd(10'h3D5, v); check("R9 prediv untouched", v, 0);
    rd(10'h3C2, v); check("R9 misc readback", v, 8'h0C);
    settle();
    period(0, p); check("R9 rate unchanged by ignored writes", p, 5);
  endtask

  initial begin
    t_reset();
    t_select();
    t_half();
    t_pre();
    t_width();
    t_boundary();
    t_ignore();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule